// File: doc/BRIEF.md
# Flash Read-Data Selector with Write Status and Identification

This block is the read-data path of a parallel NOR flash. On every read strobe it registers one data word, and what that word holds depends on the busy flag and the current access mode. When no internal write runs and the mode is plain read, the word is the array data. While a program or erase runs inside the device, the word is a status word. Software polls the status word to find out when the operation has finished.

In the status word, bit 7 is an inverted-data flag and bit 6 is a toggle that changes on each read. In identification mode, the block returns the manufacturer code or the device code. In query mode, it returns words from a small table indexed by the address.

The command decoder drives the mode, the busy flag, the operation type, the latched program word, and a one-cycle start pulse. The start pulse comes with the final command write that launches an internal operation. The array itself sits outside the block.

Top module: `nor_rd_path`

## Requirements
- R1: After reset, `rdata_o` is 0000h, and the status toggle starts from 0.
- R2: With `busy_i` low and `mode_i` = 2'b00 (read), a strobe on `rd_i` registers `array_data_i` into `rdata_o`. The new value is visible after that clock edge.
- R3: With `busy_i` high and `op_erase_i` low (program), bit 7 of the registered word is the inverse of bit 7 of `prog_data_i`.
- R4: With `busy_i` high and `op_erase_i` high (erase), bit 7 of the registered word is 0.
- R5: While busy, bit 6 of the registered word comes from a toggle. A pulse on `start_i` clears the toggle to 0, so the first busy read after a start returns 0 and later busy reads alternate 1, 0, 1, and so on.
- R6: While busy, all bits other than 7 and 6 read 0, whatever `mode_i` is.
- R7: The toggle advances only on read strobes. Clock cycles without `rd_i` leave both the toggle and `rdata_o` unchanged.
- R8: Once `busy_i` falls, reads return array data again. For example, an erased location reads FFFFh, which has bit 7 set.
- R9: With `mode_i` = 2'b01 (identification), address 0 returns 00BFh and address 1 returns the `DEV_CODE` parameter. Any other address, including one with a higher bit set, returns 0000h.
- R10: With `mode_i` = 2'b10 (query), the table returns:
  - 0051h, 0052h and 0059h at addresses 10h, 11h and 12h;
  - 0001h at 13h and 0007h at 14h;
  - 0000h at every other address.
- R11: `mode_i` = 2'b11 behaves as plain read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe, one cycle per read access |
| start_i | input | 1 | Pulse that marks the launch of an internal program or erase |
| busy_i | input | 1 | Internal program or erase in progress |
| op_erase_i | input | 1 | Operation type: 1 = erase, 0 = program |
| mode_i | input | 2 | Access mode: 00 read, 01 identification, 10 query, 11 read |
| addr_i | input | AW | Read address |
| array_data_i | input | DW | Data word from the array |
| prog_data_i | input | DW | Word being programmed |
| rdata_o | output | DW | Registered read data |

## Verification
The toggle property assumes two things about the inputs:
- `start_i` never arrives in the same cycle as `rd_i`;
- every read strobe lasts exactly one cycle.

Under those conditions, two busy reads with no start pulse between them must return opposite values of bit 6. The bench drives each read as a single-cycle pulse on a falling clock edge and issues start pulses in cycles of their own. It also holds `op_erase_i` and `prog_data_i` steady for the whole of a busy phase, so the bit-7 checks see a well-defined operation.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;
  typedef enum logic [1:0] {
    MODE_READ  = 2'b00,
    MODE_ID    = 2'b01,
    MODE_QUERY = 2'b10,
    MODE_ALT   = 2'b11
  } rd_mode_e;

  localparam logic [15:0] MFR_CODE = 16'h00BF;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TGL_BIT  = 6;
endpackage

// File: rtl/nor_busy_status.sv
module nor_busy_status import nor_rd_pkg::*; #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          start_i,
  input  logic          busy_i,
  input  logic          op_erase_i,
  input  logic          prog_b7_i,
  output logic [DW-1:0] status_o
);
  logic tgl_q;

  // toggle advances per busy read strobe; a new operation restarts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tgl_q <= 1'b0;
    else if (start_i)          tgl_q <= 1'b0;
    else if (rd_i && busy_i)   tgl_q <= ~tgl_q;
  end

  always_comb begin
    status_o           = '0;
    status_o[POLL_BIT] = op_erase_i ? 1'b0 : ~prog_b7_i;
    status_o[TGL_BIT]  = tgl_q;
  end
endmodule

// File: rtl/nor_ident_rom.sv
module nor_ident_rom import nor_rd_pkg::*; #(
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 20,
  parameter logic [15:0] DEV_CODE = 16'h5A01
) (
  input  logic          query_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] word_o
);
  localparam int unsigned QN = 5;
  localparam logic [AW-1:0] QBASE = AW'(8'h10);

  logic [15:0] q_word [QN];
  assign q_word[0] = 16'h0051;
  assign q_word[1] = 16'h0052;
  assign q_word[2] = 16'h0059;
  assign q_word[3] = 16'h0001;
  assign q_word[4] = 16'h0007;

  logic [15:0] id_word, qry_word;
  logic [QN-1:0] q_hit;

  genvar g;
  generate
    for (g = 0; g < QN; g++) begin : g_qhit
      assign q_hit[g] = (addr_i == QBASE + AW'(g));
    end
  endgenerate

  always_comb begin
    qry_word = '0;
    for (int i = 0; i < QN; i++)
      if (q_hit[i]) qry_word = q_word[i];
  end

  always_comb begin
    if (addr_i == AW'(0))      id_word = MFR_CODE;
    else if (addr_i == AW'(1)) id_word = DEV_CODE;
    else                       id_word = '0;
  end

  assign word_o = DW'(query_i ? qry_word : id_word);
endmodule

// File: rtl/nor_rd_path.sv
module nor_rd_path import nor_rd_pkg::*; #(
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 20,
  parameter logic [15:0] DEV_CODE = 16'h5A01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          start_i,
  input  logic          busy_i,
  input  logic          op_erase_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] array_data_i,
  input  logic [DW-1:0] prog_data_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] status_w, rom_w, sel_w;
  rd_mode_e      mode_w;

  wire unused_prog = ^{prog_data_i[DW-1:POLL_BIT+1], prog_data_i[POLL_BIT-1:0]};

  assign mode_w = rd_mode_e'(mode_i);

  nor_busy_status #(.DW(DW)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i),
    .start_i    (start_i),
    .busy_i     (busy_i),
    .op_erase_i (op_erase_i),
    .prog_b7_i  (prog_data_i[POLL_BIT]),
    .status_o   (status_w)
  );

  nor_ident_rom #(.DW(DW), .AW(AW), .DEV_CODE(DEV_CODE)) u_rom (
    .query_i (mode_w == MODE_QUERY),
    .addr_i  (addr_i),
    .word_o  (rom_w)
  );

  always_comb begin
    if (busy_i) sel_w = status_w;
    else begin
      unique case (mode_w)
        MODE_ID, MODE_QUERY: sel_w = rom_w;
        default:             sel_w = array_data_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= sel_w;
  end
endmodule

// File: rtl/nor_rd_path_chk.sv
module nor_rd_path_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          start_i,
  input logic          busy_i,
  input logic          op_erase_i,
  input logic [1:0]    mode_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] array_data_i,
  input logic          prog_b7_i,
  input logic [DW-1:0] rdata_o
);
  logic pend_q, have_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      have_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      pend_q <= rd_i && busy_i && !start_i;
      if (start_i) have_q <= 1'b0;
      else if (pend_q) begin
        have_q <= 1'b1;
        last_q <= rdata_o[6];
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  p_norm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !busy_i && mode_i == 2'b00 |=> rdata_o == $past(array_data_i));

  p_prog_b7_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && busy_i && !op_erase_i |=> rdata_o[7] == !$past(prog_b7_i));

  p_erase_b7_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && busy_i && op_erase_i |=> rdata_o[7] == 1'b0);

  p_busy_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && busy_i |=> (rdata_o[5:0] == '0) && (rdata_o[DW-1:8] == '0));

  p_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && have_q |-> rdata_o[6] != last_q);

  p_id_mfr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !busy_i && mode_i == 2'b01 && addr_i == '0 |=> rdata_o == DW'(16'h00BF));
endmodule

bind nor_rd_path nor_rd_path_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_i         (rd_i),
  .start_i      (start_i),
  .busy_i       (busy_i),
  .op_erase_i   (op_erase_i),
  .mode_i       (mode_i),
  .addr_i       (addr_i),
  .array_data_i (array_data_i),
  .prog_b7_i    (prog_data_i[7]),
  .rdata_o      (rdata_o)
);

// File: tb/nor_rd_path_test.sv
module nor_rd_path_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 20;
  localparam logic [15:0] DEV = 16'h5A01;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rd_i = 1'b0, start_i = 1'b0, busy_i = 1'b0, op_erase_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] array_data_i = '0, prog_data_i = '0;
  logic [DW-1:0] rdata_o;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_rd_path #(.DW(DW), .AW(AW), .DEV_CODE(DEV)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .start_i(start_i),
    .busy_i(busy_i), .op_erase_i(op_erase_i), .mode_i(mode_i),
    .addr_i(addr_i), .array_data_i(array_data_i),
    .prog_data_i(prog_data_i), .rdata_o(rdata_o)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one-cycle strobe driven on negedge, result sampled on the next negedge
  task automatic rd_word(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr_i = a;
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic pulse_start(input logic erase, input logic [DW-1:0] pd);
    @(negedge clk);
    op_erase_i = erase;
    prog_data_i = pd;
    start_i = 1'b1;
    busy_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic t_normal();
    logic [DW-1:0] d;
    mode_i = 2'b00;
    array_data_i = 16'h1234; rd_word(20'h00003, d); check("R2 normal read", d, 16'h1234);
    array_data_i = 16'hA5C3; rd_word(20'h80000, d); check("R2 normal read", d, 16'hA5C3);
    mode_i = 2'b11;
    array_data_i = 16'h0F0E; rd_word(20'h00010, d); check("R11 mode 11 reads array", d, 16'h0F0E);
    mode_i = 2'b00;
  endtask

  task automatic t_hold();
    array_data_i = 16'h7777;
    repeat (4) @(negedge clk);
    check("R7 no strobe holds output", rdata_o, 16'h0F0E);
  endtask

  task automatic t_program();
    logic [DW-1:0] d;
    pulse_start(1'b0, 16'h3C80);
    rd_word('0, d); check("R3 prog b7 inverted, R5 first toggle 0", d, 16'h0000);
    rd_word('0, d); check("R5 toggle 1", d, 16'h0040);
    repeat (5) @(negedge clk);
    rd_word('0, d); check("R7 idle cycles do not toggle", d, 16'h0000);
    mode_i = 2'b01;
    rd_word('0, d); check("R6 busy overrides id mode", d, 16'h0040);
    mode_i = 2'b00;
    busy_i = 1'b0;
    array_data_i = 16'h3C80;
    rd_word('0, d); check("R8 program done returns true data", d, 16'h3C80);
    pulse_start(1'b0, 16'hFF7F);
    rd_word('0, d); check("R3 prog b7=0 reads 1, R5 restart at 0", d, 16'h0080);
    rd_word('0, d); check("R3 R6 status only bits 7 6", d, 16'h00C0);
    busy_i = 1'b0;
  endtask

  task automatic t_erase();
    logic [DW-1:0] d;
    pulse_start(1'b1, 16'h0000);
    array_data_i = 16'h1111;
    rd_word('0, d); check("R4 erase b7 zero", d, 16'h0000);
    rd_word('0, d); check("R4 R5 erase toggle", d, 16'h0040);
    busy_i = 1'b0;
    array_data_i = 16'hFFFF;
    rd_word('0, d); check("R8 erase done reads FFFF", d, 16'hFFFF);
  endtask

  task automatic t_ident();
    logic [DW-1:0] d;
    mode_i = 2'b01;
    rd_word(20'h00000, d); check("R9 manufacturer code", d, 16'h00BF);
    rd_word(20'h00001, d); check("R9 device code", d, DEV);
    rd_word(20'h00002, d); check("R9 other address zero", d, 16'h0000);
    rd_word(20'h40000, d); check("R9 high bit set zero", d, 16'h0000);
    mode_i = 2'b00;
  endtask

  task automatic t_query();
    logic [DW-1:0] d;
    mode_i = 2'b10;
    rd_word(20'h10, d); check("R10 Q", d, 16'h0051);
    rd_word(20'h11, d); check("R10 R", d, 16'h0052);
    rd_word(20'h12, d); check("R10 Y", d, 16'h0059);
    rd_word(20'h13, d); check("R10 13h", d, 16'h0001);
    rd_word(20'h14, d); check("R10 14h", d, 16'h0007);
    rd_word(20'h15, d); check("R10 unlisted zero", d, 16'h0000);
    rd_word(20'h10010, d); check("R10 high bit zero", d, 16'h0000);
    mode_i = 2'b00;
  endtask

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    check("R1 reset output", rdata_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    busy_i = 1'b1;
    rd_word('0, d); check("R1 toggle starts 0", d, 16'h0080);
    busy_i = 1'b0;
    t_normal();
    t_hold();
    t_program();
    t_erase();
    t_ident();
    t_query();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule